// File: doc/BRIEF.md
# Wide-Screen Signalling Line Serializer

This block turns the wide-screen signalling payload for one video line into a serial bit stream. A 14-bit signalling word and a 6-bit check word come from programmable registers. A start strobe marks the opening of the signalling window on the line. The block then sends the bits one at a time and holds each bit for a programmable number of pixel-clock cycles. A bit-valid flag marks the transfer and a one-cycle done flag marks its end.

The standard select decides the length of the burst. With the 525-line standard chosen, the six check bits follow straight after the signalling bits, for 20 bits in all. With the 625-line standard chosen, only the 14 signalling bits are sent and the check word is never used. The check word belongs to the even-field signalling line. Working out its value, choosing the line and modulating the bits onto the analog waveform are all done outside this block.

Top module: `wss_serializer`

## Requirements
- R1: After reset, `ser_out`, `bit_valid` and `done` are all low.
- R2: A `start` pulse seen on a clock edge while `enable` is high and no transfer is running is accepted. From the next cycle, `bit_valid` is high and `ser_out` carries bit 0 of `data_word`.
- R3: The signalling bits go out least significant first: `data_word[0]`, then `data_word[1]`, up to `data_word[13]`.
- R4: When `std_pal` is 0 (525-line standard), `crc_word[0]` through `crc_word[5]` follow straight after `data_word[13]`, least significant first. The transfer is then 20 bits long.
- R5: When `std_pal` is 1 (625-line standard), the transfer ends after `data_word[13]`. The value of `crc_word` has no effect on the output.
- R6: Each bit stays on `ser_out` with `bit_valid` high for exactly `bit_period` cycles. A `bit_period` of 0 counts as 1.
- R7: `done` is high for exactly one cycle, in the first cycle after the last bit period. In that cycle `bit_valid` is already low.
- R8: A `start` pulse that arrives while a transfer is running is ignored. The bit stream in progress goes on unchanged.
- R9: A `start` pulse that arrives while `enable` is low is ignored, and no transfer begins.
- R10: Whenever `bit_valid` is low, `ser_out` is low.
- R11: `std_pal`, `data_word`, `crc_word` and `bit_period` are captured when `start` is accepted. Changing them during a transfer does not alter that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1x pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Strobe aligned to the signalling window |
| enable | input | 1 | Signalling enable |
| std_pal | input | 1 | 1 selects the 625-line standard, 0 the 525-line standard |
| data_word | input | 14 | Signalling data bits |
| crc_word | input | 6 | Check bits for the even-field line |
| bit_period | input | 8 | Clock cycles per bit (0 counts as 1) |
| ser_out | output | 1 | Serial bit |
| bit_valid | output | 1 | High while a bit is being sent |
| done | output | 1 | One-cycle pulse after the last bit |

## Verification
The in-design assertions check, on every cycle, that the output is quiet when idle and that `done` is a lone pulse outside the transfer. They also check that a bit stays stable for its whole period, that the bit index never passes the length set by the standard, and that a running transfer cannot be cut short. Only the bench scenarios can show the actual bit order and values. The same goes for the added check field in the 525-line case against its absence in the 625-line case, the exact count of cycles per bit including the zero setting, and the fact that a start pulse during a transfer or while disabled has no effect.

// File: rtl/wss_pkg.sv
package wss_pkg;
   localparam int unsigned WSS_DATA_BITS = 14;
   localparam int unsigned WSS_CHK_BITS  = 6;
   localparam int unsigned WSS_PER_BITS  = 8;

   typedef enum logic {
      STD_525 = 1'b0,
      STD_625 = 1'b1
   } wss_std_e;
endpackage

// File: rtl/wss_bit_timer.sv
module wss_bit_timer #(
   parameter int unsigned PER_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             run,
   input  logic [PER_W-1:0] period,
   output logic             bit_end,
   output logic             first_cyc
);
   generate
      if (PER_W < 1) begin : g_bad_per
         $error("wss_bit_timer: PER_W must be at least 1");
      end
   endgenerate

   logic [PER_W-1:0] cnt_q;
   logic [PER_W-1:0] limit;

   assign limit     = (period == '0) ? '0 : period - 1'b1;
   assign bit_end   = run && (cnt_q >= limit);
   assign first_cyc = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= '0;
      end else if (run) begin
         cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
      end
   end

   // R6
   cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q <= limit));
endmodule

// File: rtl/wss_shift_reg.sv
module wss_shift_reg #(
   parameter int unsigned W         = 20,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         shift,
   input  logic [W-1:0] din,
   output logic         head
);
   generate
      if (W < 2) begin : g_bad_w
         $error("wss_shift_reg: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] sr_q;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign head = sr_q[0];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     sr_q <= '0;
            else if (load)  sr_q <= din;
            else if (shift) sr_q <= {1'b0, sr_q[W-1:1]};
         end
      end else begin : g_msb
         assign head = sr_q[W-1];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     sr_q <= '0;
            else if (load)  sr_q <= din;
            else if (shift) sr_q <= {sr_q[W-2:0], 1'b0};
         end
      end
   endgenerate
endmodule

// File: rtl/wss_serializer.sv
module wss_serializer
   import wss_pkg::*;
#(
   parameter int unsigned DATA_W = WSS_DATA_BITS,
   parameter int unsigned CRC_W  = WSS_CHK_BITS,
   parameter int unsigned PER_W  = WSS_PER_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              enable,
   input  logic              std_pal,
   input  logic [DATA_W-1:0] data_word,
   input  logic [CRC_W-1:0]  crc_word,
   input  logic [PER_W-1:0]  bit_period,
   output logic              ser_out,
   output logic              bit_valid,
   output logic              done
);
   localparam int unsigned TOT_W = DATA_W + CRC_W;
   localparam int unsigned IDX_W = $clog2(TOT_W + 1);
   localparam logic [IDX_W-1:0] LAST_625 = IDX_W'(DATA_W - 1);
   localparam logic [IDX_W-1:0] LAST_525 = IDX_W'(TOT_W - 1);

   generate
      if (DATA_W < 1 || CRC_W < 1) begin : g_bad_fields
         $error("wss_serializer: DATA_W and CRC_W must be at least 1");
      end
   endgenerate

   logic             busy_q;
   logic             done_q;
   wss_std_e         std_q;
   logic [IDX_W-1:0] idx_q;
   logic [PER_W-1:0] per_q;
   logic             accept;
   logic             bit_end;
   logic             first_cyc;
   logic             last_bit;
   logic             finish;
   logic             head;
   logic [IDX_W-1:0] last_idx;

   assign accept   = start && enable && !busy_q;
   assign last_idx = (std_q == STD_625) ? LAST_625 : LAST_525;
   assign last_bit = (idx_q == last_idx);
   assign finish   = busy_q && bit_end && last_bit;

   wss_bit_timer #(.PER_W(PER_W)) i_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .run       (busy_q),
      .period    (per_q),
      .bit_end   (bit_end),
      .first_cyc (first_cyc)
   );

   wss_shift_reg #(.W(TOT_W), .LSB_FIRST(1'b1)) i_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .shift (busy_q && bit_end && !last_bit),
      .din   ({crc_word, data_word}),
      .head  (head)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         std_q  <= STD_525;
         idx_q  <= '0;
         per_q  <= '0;
      end else begin
         done_q <= finish;
         if (accept) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            std_q  <= wss_std_e'(std_pal);
            per_q  <= bit_period;
         end else if (busy_q && bit_end) begin
            if (last_bit) busy_q <= 1'b0;
            else          idx_q  <= idx_q + 1'b1;
         end
      end
   end

   assign ser_out   = busy_q && head;
   assign bit_valid = busy_q;
   assign done      = done_q;

   // R10
   idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_valid |-> !ser_out);

   // R7
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7
   done_after_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!bit_valid && $past(bit_valid)));

   // R6
   bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_valid && $past(bit_valid) && !first_cyc) |-> $stable(ser_out));

   // R5
   length_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (idx_q <= last_idx));

   // R8
   no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !finish) |=> busy_q);
endmodule

// File: tb/test_wss_serializer.sv
module test_wss_serializer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        enable = 1'b0;
   logic        std_pal = 1'b0;
   logic [13:0] data_word = '0;
   logic [5:0]  crc_word = '0;
   logic [7:0]  bit_period = 8'd1;
   logic        ser_out;
   logic        bit_valid;
   logic        done;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   wss_serializer i_wss_serializer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .enable     (enable),
      .std_pal    (std_pal),
      .data_word  (data_word),
      .crc_word   (crc_word),
      .bit_period (bit_period),
      .ser_out    (ser_out),
      .bit_valid  (bit_valid),
      .done       (done)
   );

   task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // R2 R3 R4 R5 R6 R7 R8 R11
   task automatic run_xfer(input logic pal, input logic [13:0] d, input logic [5:0] c,
                           input logic [7:0] per, input logic disturb);
      int nbits = pal ? 14 : 20;
      int eff = (per == 0) ? 1 : per;
      int bad = 0;
      @(negedge clk);
      enable = 1'b1; std_pal = pal; data_word = d; crc_word = c; bit_period = per;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R2 first bit", {bit_valid, ser_out, done}, {1'b1, d[0], 1'b0});
      for (int i = 0; i < nbits; i++) begin
         for (int k = 0; k < eff; k++) begin
            logic e = (i < 14) ? d[i] : c[i - 14];
            if (i == 0 && k == 0) begin
               @(negedge clk);
               continue;
            end
            if (disturb && i == 5 && k == 0) begin
               start = 1'b1; std_pal = ~pal; data_word = ~d; crc_word = ~c;
               bit_period = per + 8'd3;
            end else begin
               start = 1'b0;
            end
            if ({bit_valid, ser_out, done} !== {1'b1, e, 1'b0}) begin
               bad++;
               $display("FAIL %s bit %0d cyc %0d: actual %b expected %b",
                        pal ? "R3/R5/R6/R8/R11" : "R3/R4/R6/R8/R11", i, k,
                        {bit_valid, ser_out, done}, {1'b1, e, 1'b0});
            end
            @(negedge clk);
         end
      end
      start = 1'b0;
      n_chk++;
      if (bad != 0) n_fail++;
      check("R7 done pulse", {bit_valid, ser_out, done}, 3'b001);
      @(negedge clk);
      check("R7 done clears R10 idle low", {bit_valid, ser_out, done}, 3'b000);
   endtask

   // R9
   task automatic disabled_start();
      int seen = 0;
      @(negedge clk);
      enable = 1'b0; data_word = 14'h3FFF; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 10; i++) begin
         if (bit_valid || ser_out || done) seen++;
         @(negedge clk);
      end
      check("R9 start ignored while disabled", {2'b00, seen != 0}, 3'b000);
   endtask

   initial begin : watchdog
      #1_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #1;
      check("R1 reset state", {bit_valid, ser_out, done}, 3'b000);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", {bit_valid, ser_out, done}, 3'b000);
      run_xfer(1'b0, 14'h2A5C, 6'h2D, 8'd1, 1'b0);
      run_xfer(1'b0, 14'h1234, 6'h13, 8'd3, 1'b0);
      run_xfer(1'b1, 14'h3C0F, 6'h3F, 8'd2, 1'b0);
      run_xfer(1'b0, 14'h0001, 6'h20, 8'd0, 1'b0);
      run_xfer(1'b0, 14'h1B6D, 6'h15, 8'd2, 1'b1);
      run_xfer(1'b1, 14'h2D2D, 6'h0A, 8'd4, 1'b1);
      disabled_start();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule